// File: doc/BRIEF.md
# Mode Select and Power-Down Controller

This block sits between a small mode-control bus and two signal detectors of a line-interface receiver: a frequency-shift-keyed data demodulator and a dual-tone alert detector. It filters the control code so that only a code held unchanged for a set number of clock cycles takes effect. The filtered code selects FSK receive, alert-tone detect or power down. The block then enables only the detector that the selected function needs, and it gates the receiver's output pins.

In power down, the oscillator, reference and input-amplifier enables are all dropped, and every output pin is forced to a defined idle level. Bit 0 of the code chooses the data-clock direction, and the power-down code always has that bit set, so the data-clock pin is an input while powered down. The analog parts appear only as enable outputs.

Top module: `mode_power_ctl`

## Requirements
- R1: While `rst` is high and in the cycle after it, the block reports power down (`pwr_down`=1, `dclk_is_input`=1). All enables are 0, `data_o`, `ready_o` and `cd_n_o` are 1, and `est_o` and `gt_o` are 0.
- R2: A code is driven on `mode_code` just after a clock edge. If it stays there, all mode outputs and enables change on the STABLE_CYCLES+3rd rising edge after the change and not earlier.
- R3: A code present for fewer than STABLE_CYCLES consecutive rising edges has no effect on any output, including a brief pass through the power-down code 3'b111.
- R4: In power down, `data_o`, `ready_o` and `cd_n_o` are 1 and `est_o` and `gt_o` are 0, whatever the detector inputs are.
- R5: In power down, `osc_en`, `vref_en`, `fsk_en`, `cas_en` and every bit of `amp_en` are 0.
- R6: `dclk_is_input` equals bit 0 of the adopted code, so it is 1 in power down.
- R7: The FSK mode uses codes with bit 2 clear (3'b000 to 3'b011). In this mode `fsk_en`=1 and `cas_en`=0. `data_o`, `ready_o` and `cd_n_o` follow `dem_data`, `dem_ready_n` and `dem_cd_n` with one cycle of delay, and `est_o` and `gt_o` are 0.
- R8: The alert-tone mode uses codes 3'b100 to 3'b110. In this mode `cas_en`=1 and `fsk_en`=0. `ready_o` follows `cas_std_n` and `est_o`/`gt_o` follow `cas_est`/`cas_gt`, each with one cycle of delay, and `data_o` and `cd_n_o` are 1.
- R9: In the FSK and alert-tone modes, `osc_en`, `vref_en` and all `amp_en` bits are 1, and `pwr_down` is 0.
- R10: Leaving power down restores all enables in the same cycle in which the new mode appears, with the latency given in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_code | input | CODE_W | Raw mode-control code |
| dem_data | input | 1 | Demodulated FSK data |
| dem_ready_n | input | 1 | Demodulator byte-ready, active low |
| dem_cd_n | input | 1 | Carrier detect, active low |
| cas_std_n | input | 1 | Alert-tone steering output, active low |
| cas_est | input | 1 | Alert-tone early steering |
| cas_gt | input | 1 | Alert-tone steering/guard level |
| data_o | output | 1 | Data pin |
| ready_o | output | 1 | Ready / steering pin |
| cd_n_o | output | 1 | Carrier-detect pin |
| est_o | output | 1 | Early-steering pin |
| gt_o | output | 1 | Steering/guard pin |
| dclk_is_input | output | 1 | Data-clock pin direction, 1 = input |
| fsk_en | output | 1 | FSK demodulator enable |
| cas_en | output | 1 | Alert-tone detector enable |
| osc_en | output | 1 | Oscillator enable |
| vref_en | output | 1 | Reference enable |
| amp_en | output | AMP_N | Input amplifier enables |
| pwr_down | output | 1 | Power-down state |

## Verification
A wrong filter count or comparison shows up at the ports in one of two ways. The mode may change one or more edges away from STABLE_CYCLES+3, or a glitch shorter than the window may reach `pwr_down` or the enables. The bench therefore samples one cycle before and one cycle at the expected switch for every code. A wrong decode or pin gate shows up one cycle after the input changes, as a pin level or an enable that disagrees with the mode table. The bench sweeps all detector input combinations in every mode to catch this.

// File: rtl/mode_ctl_pkg.sv
package mode_ctl_pkg;
  typedef enum logic [1:0] {
    MODE_OFF = 2'd0,
    MODE_FSK = 2'd1,
    MODE_CAS = 2'd2
  } mode_e;

  function automatic mode_e decode_mode(input logic [2:0] code, input logic [2:0] off_code);
    if (code == off_code) return MODE_OFF;
    else if (code[2]) return MODE_CAS;
    else return MODE_FSK;
  endfunction
endpackage

// File: rtl/mode_code_filter.sv
module mode_code_filter #(
  parameter int CODE_W = 3,
  parameter int STABLE_CYCLES = 64,
  parameter logic [CODE_W-1:0] RESET_CODE = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code_in,
  output logic [CODE_W-1:0] code_ok
);
  localparam int CNT_W = $clog2(STABLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(STABLE_CYCLES);

  logic [CODE_W-1:0] code_q;
  logic [CNT_W-1:0]  run_cnt;
  logic              same;

  assign same = (code_in == code_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q  <= RESET_CODE;
      run_cnt <= '0;
      code_ok <= RESET_CODE;
    end else begin
      code_q <= code_in;
      if (!same) run_cnt <= '0;
      else if (run_cnt != LIMIT) run_cnt <= run_cnt + 1'b1;
      if (same && run_cnt == LIMIT) code_ok <= code_q;
    end
  end

  // R3: a changing input never moves the adopted code on the next edge
  assert_glitch_held_R3: assert property (@(posedge clk) disable iff (rst)
    (code_in != code_q) |=> $stable(code_ok));
  // R2: the run counter saturates at the window length
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
    run_cnt <= LIMIT);
endmodule

// File: rtl/mode_enable_gen.sv
module mode_enable_gen
  import mode_ctl_pkg::*;
#(
  parameter int CODE_W = 3,
  parameter int AMP_N = 2,
  parameter logic [CODE_W-1:0] OFF_CODE = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code_ok,
  output logic              fsk_en,
  output logic              cas_en,
  output logic              osc_en,
  output logic              vref_en,
  output logic [AMP_N-1:0]  amp_en,
  output logic              dclk_is_input,
  output logic              pwr_down
);
  mode_e mode;
  assign mode = decode_mode(3'(code_ok), 3'(OFF_CODE));

  always_ff @(posedge clk) begin
    if (rst) begin
      fsk_en        <= 1'b0;
      cas_en        <= 1'b0;
      osc_en        <= 1'b0;
      vref_en       <= 1'b0;
      amp_en        <= '0;
      dclk_is_input <= 1'b1;
      pwr_down      <= 1'b1;
    end else begin
      fsk_en        <= (mode == MODE_FSK);
      cas_en        <= (mode == MODE_CAS);
      osc_en        <= (mode != MODE_OFF);
      vref_en       <= (mode != MODE_OFF);
      amp_en        <= (mode != MODE_OFF) ? '1 : '0;
      dclk_is_input <= code_ok[0];
      pwr_down      <= (mode == MODE_OFF);
    end
  end

  // R7/R8: never both detectors at once
  assert_one_detector_R7: assert property (@(posedge clk) disable iff (rst)
    !(fsk_en && cas_en));
endmodule

// File: rtl/mode_pin_gate.sv
module mode_pin_gate
  import mode_ctl_pkg::*;
#(
  parameter int CODE_W = 3,
  parameter logic [CODE_W-1:0] OFF_CODE = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code_ok,
  input  logic              dem_data,
  input  logic              dem_ready_n,
  input  logic              dem_cd_n,
  input  logic              cas_std_n,
  input  logic              cas_est,
  input  logic              cas_gt,
  output logic              data_o,
  output logic              ready_o,
  output logic              cd_n_o,
  output logic              est_o,
  output logic              gt_o
);
  mode_e mode;
  assign mode = decode_mode(3'(code_ok), 3'(OFF_CODE));

  always_ff @(posedge clk) begin
    if (rst) begin
      data_o  <= 1'b1;
      ready_o <= 1'b1;
      cd_n_o  <= 1'b1;
      est_o   <= 1'b0;
      gt_o    <= 1'b0;
    end else begin
      case (mode)
        MODE_FSK: begin
          data_o  <= dem_data;
          ready_o <= dem_ready_n;
          cd_n_o  <= dem_cd_n;
          est_o   <= 1'b0;
          gt_o    <= 1'b0;
        end
        MODE_CAS: begin
          data_o  <= 1'b1;
          ready_o <= cas_std_n;
          cd_n_o  <= 1'b1;
          est_o   <= cas_est;
          gt_o    <= cas_gt;
        end
        default: begin
          data_o  <= 1'b1;
          ready_o <= 1'b1;
          cd_n_o  <= 1'b1;
          est_o   <= 1'b0;
          gt_o    <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/mode_power_ctl.sv
module mode_power_ctl #(
  parameter int CODE_W = 3,
  parameter int STABLE_CYCLES = 64,
  parameter int AMP_N = 2,
  parameter logic [CODE_W-1:0] OFF_CODE = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] mode_code,
  input  logic              dem_data,
  input  logic              dem_ready_n,
  input  logic              dem_cd_n,
  input  logic              cas_std_n,
  input  logic              cas_est,
  input  logic              cas_gt,
  output logic              data_o,
  output logic              ready_o,
  output logic              cd_n_o,
  output logic              est_o,
  output logic              gt_o,
  output logic              dclk_is_input,
  output logic              fsk_en,
  output logic              cas_en,
  output logic              osc_en,
  output logic              vref_en,
  output logic [AMP_N-1:0]  amp_en,
  output logic              pwr_down
);
  logic [CODE_W-1:0] code_ok;

  mode_code_filter #(.CODE_W(CODE_W), .STABLE_CYCLES(STABLE_CYCLES), .RESET_CODE(OFF_CODE)) u_filt (
    .clk(clk), .rst(rst), .code_in(mode_code), .code_ok(code_ok));

  mode_enable_gen #(.CODE_W(CODE_W), .AMP_N(AMP_N), .OFF_CODE(OFF_CODE)) u_en (
    .clk(clk), .rst(rst), .code_ok(code_ok),
    .fsk_en(fsk_en), .cas_en(cas_en), .osc_en(osc_en), .vref_en(vref_en),
    .amp_en(amp_en), .dclk_is_input(dclk_is_input), .pwr_down(pwr_down));

  mode_pin_gate #(.CODE_W(CODE_W), .OFF_CODE(OFF_CODE)) u_pins (
    .clk(clk), .rst(rst), .code_ok(code_ok),
    .dem_data(dem_data), .dem_ready_n(dem_ready_n), .dem_cd_n(dem_cd_n),
    .cas_std_n(cas_std_n), .cas_est(cas_est), .cas_gt(cas_gt),
    .data_o(data_o), .ready_o(ready_o), .cd_n_o(cd_n_o), .est_o(est_o), .gt_o(gt_o));

  assert_pd_pins_R4: assert property (@(posedge clk) disable iff (rst)
    pwr_down |-> (data_o && ready_o && cd_n_o && !est_o && !gt_o));
  assert_pd_enables_R5: assert property (@(posedge clk) disable iff (rst)
    pwr_down |-> (!osc_en && !vref_en && !fsk_en && !cas_en && amp_en == '0));
  assert_pd_dclk_R6: assert property (@(posedge clk) disable iff (rst)
    pwr_down |-> dclk_is_input);
  assert_active_amps_R9: assert property (@(posedge clk) disable iff (rst)
    !pwr_down |-> (amp_en == '1 && osc_en && vref_en && (fsk_en || cas_en)));
  assert_pins_match_mode_R8: assert property (@(posedge clk) disable iff (rst)
    fsk_en |-> (!est_o && !gt_o));
endmodule

// File: tb/sim_mode_power_ctl.sv
module sim_mode_power_ctl;
  localparam int ST = 8;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] mode_code = 3'b111;
  logic dem_data = 0, dem_ready_n = 0, dem_cd_n = 0, cas_std_n = 0, cas_est = 0, cas_gt = 0;
  logic data_o, ready_o, cd_n_o, est_o, gt_o, dclk_is_input, fsk_en, cas_en, osc_en, vref_en, pwr_down;
  logic [1:0] amp_en;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mode_power_ctl #(.CODE_W(3), .STABLE_CYCLES(ST), .AMP_N(2), .OFF_CODE(3'b111)) u0 (
    .clk(clk), .rst(rst), .mode_code(mode_code),
    .dem_data(dem_data), .dem_ready_n(dem_ready_n), .dem_cd_n(dem_cd_n),
    .cas_std_n(cas_std_n), .cas_est(cas_est), .cas_gt(cas_gt),
    .data_o(data_o), .ready_o(ready_o), .cd_n_o(cd_n_o), .est_o(est_o), .gt_o(gt_o),
    .dclk_is_input(dclk_is_input), .fsk_en(fsk_en), .cas_en(cas_en), .osc_en(osc_en),
    .vref_en(vref_en), .amp_en(amp_en), .pwr_down(pwr_down));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {pwr_down, dclk_is_input, fsk_en, cas_en, osc_en, vref_en, amp_en}
  function automatic logic [7:0] exp_en(input logic [2:0] c);
    logic pd;
    pd = (c == 3'b111);
    return {pd, c[0], !pd && !c[2], !pd && c[2], !pd, !pd, pd ? 2'b00 : 2'b11};
  endfunction

  function automatic logic [4:0] exp_pins(input logic [2:0] c, input logic [5:0] v);
    if (c == 3'b111) return 5'b11100;
    else if (c[2]) return {1'b1, v[3], 1'b1, v[4], v[5]};
    else return {v[0], v[1], v[2], 2'b00};
  endfunction

  function automatic logic [7:0] act_en();
    return {pwr_down, dclk_is_input, fsk_en, cas_en, osc_en, vref_en, amp_en};
  endfunction

  function automatic logic [4:0] act_pins();
    return {data_o, ready_o, cd_n_o, est_o, gt_o};
  endfunction

  task automatic set_in(input logic [5:0] v);
    {cas_gt, cas_est, cas_std_n, dem_cd_n, dem_ready_n, dem_data} = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2:0] cur;
    set_in(6'b010101);
    step(3);
    // R1: reset state while in reset
    chk(act_en() == exp_en(3'b111), "R1 enables in reset", act_en(), exp_en(3'b111));
    chk(act_pins() == 5'b11100, "R1 pins in reset", act_pins(), 5'b11100);
    rst = 1'b0;
    step(1);
    chk(act_en() == exp_en(3'b111) && act_pins() == 5'b11100, "R1 after reset",
        {act_en(), act_pins()}, {exp_en(3'b111), 5'b11100});
    cur = 3'b111;
    for (int t = 0; t < 8; t++) begin
      // return to power down first
      mode_code = 3'b111;
      step(ST + 5);
      chk(act_en() == exp_en(3'b111), "R5 power down enables", act_en(), exp_en(3'b111));
      mode_code = 3'(t);
      step(ST + 2);
      chk(act_en() == exp_en(3'b111), "R2 not yet adopted", act_en(), exp_en(3'b111));
      step(1);
      chk(act_en() == exp_en(3'(t)), "R2 R10 adopted on time", act_en(), exp_en(3'(t)));
      chk(dclk_is_input == t[0], "R6 dclk direction", dclk_is_input, t[0]);
      if (t != 7) chk(amp_en == 2'b11 && osc_en && vref_en, "R9 active enables", act_en(), exp_en(3'(t)));
      for (int v = 0; v < 64; v++) begin
        set_in(6'(v));
        step(1);
        chk(act_pins() == exp_pins(3'(t), 6'(v)),
            (t == 7) ? "R4 pd pin levels" : (t >= 4 ? "R8 alert pins" : "R7 fsk pins"),
            act_pins(), exp_pins(3'(t), 6'(v)));
      end
    end
    // R3: short glitches into power down and into alert mode from FSK
    mode_code = 3'b000;
    step(ST + 5);
    for (int g = 1; g < ST; g++) begin
      for (int k = 0; k < 2; k++) begin
        mode_code = (k == 0) ? 3'b111 : 3'b101;
        step(g);
        mode_code = 3'b000;
        for (int w = 0; w < ST + 4; w++) begin
          step(1);
          chk(act_en() == exp_en(3'b000), "R3 glitch ignored", act_en(), exp_en(3'b000));
        end
      end
    end
    // R3: alternating codes never settle
    for (int w = 0; w < 4 * ST; w++) begin
      mode_code = w[0] ? 3'b111 : 3'b110;
      step(1);
      chk(act_en() == exp_en(3'b000), "R3 toggling ignored", act_en(), exp_en(3'b000));
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule